// File: doc/BRIEF.md
# Left-Justified Stereo Serial Audio Receiver

This block receives stereo audio from an external serial transmitter that drives the bit clock, the frame select and the data line. The receiver is always the slave. It takes the three lines into the system clock domain and finds each rising edge of the bit clock. On every such edge it samples the data line. It builds one 16-bit word per half-frame and emits each completed left/right pair on two parallel words, together with a one-cycle strobe.

The receiver accepts only the left-justified layout at normal polarity. A change of the frame select marks the start of a sample, and the most significant bit is on the line in that same bit period, with no one-bit delay. Frame select high carries the left channel and low carries the right channel. Every frame holds exactly two channels. Supported frame rates are 44.1 kHz and 48 kHz. The system clock must run at least four times faster than the bit clock. A half-frame that ends before its sixteenth bit is discarded and sets an error flag, which stays set until reset.

Top module: `lj_audio_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pair_valid_o` and `fmt_err_o` are 0 and both sample words read 0.
- R2: The sample is formed from the first 16 bits after a frame-select change, most significant bit first. The bit present in the same bit-clock period as the change is bit 15.
- R3: Frame select 1 selects the left channel and frame select 0 selects the right channel. A pair is presented only when a right sample completes after a completed left sample, and it carries that left sample on `left_o` and the right sample on `right_o`.
- R4: `pair_valid_o` is high for exactly one system cycle per pair, and the sample words change only in a cycle where it is high.
- R5: Bit clocks beyond the sixteenth in a half-frame do not change any sample.
- R6: A frame-select change that arrives before 16 bits of the current half-frame have been taken discards the partial sample, sets `fmt_err_o`, and produces no pair for that frame.
- R7: `fmt_err_o` remains 1 until reset and is cleared only by reset. Decoding of later well-formed frames continues while it is set.
- R8: Data is taken only at rising bit-clock edges. A change of the data line while the bit clock is high has no effect.
- R9: After reset, bits received before the first frame-select change are neither decoded nor counted as an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock from the external transmitter |
| ch_sel_i | input | 1 | Frame select: 1 for left, 0 for right |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| pair_valid_o | output | 1 | One-cycle strobe for a new stereo pair |
| left_o | output | 16 | Left sample of the latest pair |
| right_o | output | 16 | Right sample of the latest pair |
| fmt_err_o | output | 1 | Sticky flag for a short half-frame |

## Verification
The bench builds the block with its default values: a 16-bit sample and two synchroniser stages. The bit clock runs at about one eighth of the system clock. At that ratio the bench has several system cycles inside each bit-clock phase, so it can flip the data line in the middle of the high phase and hold the line steady across the rising edge. It can also add surplus bit clocks, or end a half-frame after ten bits, with every edge still detected.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } lj_chan_e;

endpackage

// File: rtl/lj_rx_sync.sv
module lj_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = async_i;
            end else begin : g_next
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lj_rx_edge.sv
module lj_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sel_s,
    input  logic dat_s,
    output logic tick_o,
    output logic sel_o,
    output logic dat_o
);

    typedef struct packed {
        logic sclk_prev;
        logic tick;
        logic sel;
        logic dat;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.tick      = sclk_s & ~st_q.sclk_prev;
        if (sclk_s & ~st_q.sclk_prev) begin
            st_d.sel = sel_s;
            st_d.dat = dat_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign sel_o  = st_q.sel;
    assign dat_o  = st_q.dat;

endmodule

// File: rtl/lj_rx_deser.sv
module lj_rx_deser
    import lj_rx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                sel_i,
    input  logic                dat_i,
    output logic                pair_valid_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                fmt_err_o
);

    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

    typedef struct packed {
        logic                armed;
        logic                active;
        lj_chan_e            chan;
        logic                sel_last;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] left_hold;
        logic                have_left;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                valid;
        logic                err;
    } deser_st_t;

    deser_st_t st_d, st_q;
    logic [SAMPLE_W-1:0] word_next;

    assign word_next = {st_q.shreg[SAMPLE_W-2:0], dat_i};

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (tick_i) begin
            if (!st_q.armed) begin
                st_d.armed    = 1'b1;
                st_d.sel_last = sel_i;
            end else if (sel_i != st_q.sel_last) begin
                st_d.sel_last = sel_i;
                if (st_q.active && (st_q.cnt < CNT_FULL)) begin
                    st_d.err       = 1'b1;
                    st_d.have_left = 1'b0;
                end
                st_d.active = 1'b1;
                st_d.chan   = lj_chan_e'(sel_i);
                st_d.cnt    = CNT_W'(1);
                st_d.shreg  = {{(SAMPLE_W-1){1'b0}}, dat_i};
            end else if (st_q.active && (st_q.cnt < CNT_FULL)) begin
                st_d.shreg = word_next;
                st_d.cnt   = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_LAST) begin
                    if (st_q.chan == CH_LEFT) begin
                        st_d.left_hold = word_next;
                        st_d.have_left = 1'b1;
                    end else if (st_q.have_left) begin
                        st_d.out_l     = st_q.left_hold;
                        st_d.out_r     = word_next;
                        st_d.valid     = 1'b1;
                        st_d.have_left = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_valid_o = st_q.valid;
    assign left_o       = st_q.out_l;
    assign right_o      = st_q.out_r;
    assign fmt_err_o    = st_q.err;

endmodule

// File: rtl/lj_audio_rx.sv
module lj_audio_rx #(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk_i,
    input  logic                ch_sel_i,
    input  logic                ser_dat_i,
    output logic                pair_valid_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                fmt_err_o
);

    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lines_s;
    logic tick, sel_b, dat_b;

    lj_rx_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk_i, ch_sel_i, ser_dat_i}),
        .sync_o  (lines_s)
    );

    lj_rx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (lines_s[2]),
        .sel_s  (lines_s[1]),
        .dat_s  (lines_s[0]),
        .tick_o (tick),
        .sel_o  (sel_b),
        .dat_o  (dat_b)
    );

    lj_rx_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .sel_i        (sel_b),
        .dat_i        (dat_b),
        .pair_valid_o (pair_valid_o),
        .left_o       (left_o),
        .right_o      (right_o),
        .fmt_err_o    (fmt_err_o)
    );

endmodule

// File: rtl/lj_audio_rx_chk.sv
module lj_audio_rx_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pair_valid_o,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                fmt_err_o
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!pair_valid_o && !fmt_err_o && left_o == '0 && right_o == '0));

    p_one_cycle_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o);

    p_words_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |=> fmt_err_o);

    p_no_pair_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err_o) |-> !pair_valid_o);

endmodule

bind lj_audio_rx lj_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_valid_o (pair_valid_o),
    .left_o       (left_o),
    .right_o      (right_o),
    .fmt_err_o    (fmt_err_o)
);

// File: tb/lj_audio_rx_test.sv
module lj_audio_rx_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ch_sel = 1'b0;
    logic ser_dat = 1'b0;
    logic pair_valid;
    logic [15:0] left_w, right_w;
    logic fmt_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] exp_q [$];
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    lj_audio_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk_i    (ser_clk),
        .ch_sel_i     (ch_sel),
        .ser_dat_i    (ser_dat),
        .pair_valid_o (pair_valid),
        .left_o       (left_w),
        .right_o      (right_w),
        .fmt_err_o    (fmt_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic sel, input logic b, input logic glitch);
        @(negedge clk);
        ch_sel  = sel;
        ser_dat = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        if (glitch) begin
            repeat (2) @(negedge clk);
            ser_dat = ~b;
            repeat (2) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b0;
    endtask

    task automatic send_half(input logic sel, input logic [15:0] val, input int nbits,
                             input int extra, input logic glitch);
        for (int i = 0; i < nbits; i++) send_bit(sel, val[15-i], glitch);
        for (int i = 0; i < extra; i++) send_bit(sel, i[0], 1'b0);
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int extra,
                              input logic glitch);
        exp_q.push_back({l, r});
        send_half(1'b1, l, 16, extra, glitch);
        send_half(1'b0, r, 16, extra, glitch);
    endtask

    // Monitor: scoreboard compare and strobe width (R2, R3, R4)
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected pair actual=%h expected=none", {left_w, right_w});
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk("R2 R3 pair", {left_w, right_w}, e);
            end
            if (prev_valid) chk("R4 strobe width", 32'd1, 32'd0);
        end
        prev_valid = pair_valid;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, pair_valid}, 32'd0);
        chk("R1 err in reset", {31'd0, fmt_err}, 32'd0);
        chk("R1 words in reset", {left_w, right_w}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {31'd0, fmt_err}, 32'd0);

        // R9: bits before the first frame-select edge
        send_half(1'b0, 16'h5A00, 5, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 no error before sync", {31'd0, fmt_err}, 32'd0);
        chk("R9 nothing decoded", exp_q.size(), 32'd0);

        send_frame(16'hA5A5, 16'h5A5A, 0, 1'b0);
        send_frame(16'h8001, 16'h7FFE, 0, 1'b0);
        send_frame(16'hFFFF, 16'h0000, 0, 1'b0);
        send_frame(16'h1234, 16'hABCD, 0, 1'b0);
        // R5: surplus bit clocks
        send_frame(16'h0F0F, 16'hF0F0, 5, 1'b0);
        // R8: data flips while bit clock is high
        send_frame(16'hC3A1, 16'h3C5E, 0, 1'b1);
        repeat (8) @(negedge clk);
        chk("R5 R8 all pairs seen", exp_q.size(), 32'd0);
        chk("R6 no error yet", {31'd0, fmt_err}, 32'd0);

        // R6: short left half, full right: no pair, error set
        send_half(1'b1, 16'hDEAD, 10, 0, 1'b0);
        send_half(1'b0, 16'hBEEF, 16, 0, 1'b0);
        repeat (8) @(negedge clk);
        chk("R6 error set", {31'd0, fmt_err}, 32'd1);
        chk("R6 no pair emitted", exp_q.size(), 32'd0);

        // R7: decoding continues, error sticks
        send_frame(16'h2468, 16'h1357, 0, 1'b0);
        send_half(1'b1, 16'h1111, 16, 0, 1'b0);
        send_half(1'b0, 16'h2222, 7, 0, 1'b0);
        send_frame(16'h0102, 16'h0304, 0, 1'b0);
        repeat (8) @(negedge clk);
        chk("R7 error held", {31'd0, fmt_err}, 32'd1);
        chk("R7 later pairs decoded", exp_q.size(), 32'd0);

        // R7: reset clears the flag
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 cleared by reset", {31'd0, fmt_err}, 32'd0);
        chk("R1 words cleared", {left_w, right_w}, 32'd0);
        send_half(1'b0, 16'h0000, 2, 0, 1'b0);
        send_frame(16'h7F00, 16'h00FF, 0, 1'b0);
        repeat (8) @(negedge clk);
        chk("R3 pair after reset", exp_q.size(), 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule